// File: doc/BRIEF.md
# Single-Error-Correcting Codec for 16-bit Memory Words

This block protects a memory that stores 16-bit words. On the write side it turns each data word into a 5-bit Hamming check field, which the memory keeps next to the data. On the read side it takes a stored word and its check field and recomputes the syndrome. If the syndrome points at a data bit, it repairs that one bit. It returns the result together with an error indication. The block has no path back into the array. A repaired value appears only at the read output, and the stored bits change only when the system writes a new word.

The codeword is 21 bits long. It is numbered from position 1 to position 21. The check bits sit at the power-of-two positions 1, 2, 4, 8 and 16. Data bits 0 to 15 fill the other positions in ascending order:

| Data bits | Positions |
|---|---|
| 0 | 3 |
| 1 to 3 | 5 to 7 |
| 4 to 10 | 9 to 15 |
| 11 to 15 | 17 to 21 |

A correction-disable input makes a read return the stored data untouched and keeps the error indication low. Both paths are registered with a latency of one cycle. Each output register loads only when its own enable is high and otherwise holds its value.

Top module: `sec16_codec`

## Requirements
- R1: One cycle after a cycle with `wr_en` high, `wr_chk_vld` is 1 and `wr_chk` holds the check field of the `wr_data` sampled in that cycle. Bit k of `wr_chk` is the XOR of every data bit whose codeword position has bit k set.
- R2: `rd_q_vld` is 1 in the cycle after a cycle with `rd_en` high, and 0 otherwise. `wr_chk_vld` behaves the same way with respect to `wr_en`.
- R3: The syndrome is `rd_chk` XOR the check field recomputed from `rd_data`. When the syndrome is 0 and correction is enabled, the read returns `rd_data` unchanged and `rd_err` is 0.
- R4: When the syndrome equals the codeword position of data bit i, the read returns `rd_data` with bit i inverted and `rd_err` is 1. At most one bit is ever inverted.
- R5: When the syndrome equals one of the positions 1, 2, 4, 8 or 16, `rd_err` is 1 and `rd_data` is returned unchanged.
- R6: When the syndrome is greater than 21, `rd_err` is 1 and `rd_data` is returned unchanged.
- R7: When `ecc_off` is 1 in a read cycle, the read returns `rd_data` unchanged and `rd_err` is 0, whatever `rd_chk` is.
- R8: While reset is applied, and until the first enabled operation after it, all outputs are 0.
- R9: In a cycle with `rd_en` low, `rd_q` and `rd_err` keep their values. In a cycle with `wr_en` low, `wr_chk` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write-side encode request |
| wr_data | input | 16 | Data word to encode |
| wr_chk | output | 5 | Check field to store beside the data |
| wr_chk_vld | output | 1 | `wr_chk` was updated this cycle |
| rd_en | input | 1 | Read-side decode request |
| rd_data | input | 16 | Data word as read from the array |
| rd_chk | input | 5 | Check field as read from the array |
| ecc_off | input | 1 | Return raw data and suppress the error flag |
| rd_q | output | 16 | Corrected (or raw) read word |
| rd_q_vld | output | 1 | `rd_q` was updated this cycle |
| rd_err | output | 1 | The last read had a nonzero syndrome while correction was on |

## Verification
The assertions assume that `rd_en`, `wr_en` and `ecc_off` are never unknown, and that `rd_data` and `rd_chk` are stable from the sampling edge onward. They also assume that reset is applied for at least two clock edges before any traffic. The stimulus changes inputs only on falling edges and leaves reset low for several cycles. It also waits for the internal reset release before the first request. To reach the syndromes above 21, the stimulus flips several check bits at once rather than relying on random data patterns.

// File: rtl/sec16_pkg.sv
package sec16_pkg;

  // Smallest number of check bits k with 2**k >= data_w + k + 1.
  function automatic int chk_width(input int data_w);
    int k;
    k = 0;
    while ((1 << k) < (data_w + k + 1)) k++;
    return k;
  endfunction

  // Codeword position (1-based) of data bit idx; powers of two are skipped.
  function automatic int data_pos(input int idx);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int q = 1; q < 512; q++) begin
      if ((q & (q - 1)) != 0) begin
        if (cnt == idx && res == 0) res = q;
        cnt++;
      end
    end
    return res;
  endfunction

endpackage

// File: rtl/sec_chkgen.sv
module sec_chkgen
  import sec16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHK_W  = chk_width(DATA_W)
) (
  input  logic [DATA_W-1:0] data,
  output logic [CHK_W-1:0]  chk
);

  for (genvar k = 0; k < CHK_W; k++) begin : g_col
    logic [DATA_W-1:0] term;
    for (genvar i = 0; i < DATA_W; i++) begin : g_bit
      localparam int POS = data_pos(i);
      if (POS[k]) begin : g_use
        assign term[i] = data[i];
      end else begin : g_skip
        assign term[i] = 1'b0;
      end
    end
    assign chk[k] = ^term;
  end

endmodule

// File: rtl/sec_fix.sv
module sec_fix
  import sec16_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CHK_W  = chk_width(DATA_W)
) (
  input  logic [DATA_W-1:0] data,
  input  logic [CHK_W-1:0]  chk_in,
  input  logic              off,
  output logic [DATA_W-1:0] q,
  output logic              err,
  output logic [CHK_W-1:0]  syn
);

  logic [CHK_W-1:0]  chk_re;
  logic [DATA_W-1:0] flip;

  sec_chkgen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_regen (
    .data (data),
    .chk  (chk_re)
  );

  assign syn = chk_in ^ chk_re;

  for (genvar i = 0; i < DATA_W; i++) begin : g_flip
    localparam int POS = data_pos(i);
    localparam logic [CHK_W-1:0] POS_V = CHK_W'(POS);
    assign flip[i] = (syn == POS_V);
  end

  always_comb begin
    if (off) begin
      q   = data;
      err = 1'b0;
    end else begin
      q   = data ^ flip;
      err = |syn;
    end
  end

  always_comb begin
    AST_SINGLE_FLIP: assert ($onehot0(flip)); // R4
  end

endmodule

// File: rtl/sec16_codec.sv
module sec16_codec
  import sec16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [DATA_W-1:0]             wr_data,
  output logic [chk_width(DATA_W)-1:0]  wr_chk,
  output logic                          wr_chk_vld,
  input  logic                          rd_en,
  input  logic [DATA_W-1:0]             rd_data,
  input  logic [chk_width(DATA_W)-1:0]  rd_chk,
  input  logic                          ecc_off,
  output logic [DATA_W-1:0]             rd_q,
  output logic                          rd_q_vld,
  output logic                          rd_err
);

  localparam int CHK_W  = chk_width(DATA_W);
  localparam int CW_LEN = DATA_W + CHK_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  // datapath
  logic [CHK_W-1:0]  gen_chk;
  logic [DATA_W-1:0] fix_q;
  logic              fix_err;
  logic [CHK_W-1:0]  fix_syn;

  sec_chkgen #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_gen (
    .data (wr_data),
    .chk  (gen_chk)
  );

  sec_fix #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_fix (
    .data   (rd_data),
    .chk_in (rd_chk),
    .off    (ecc_off),
    .q      (fix_q),
    .err    (fix_err),
    .syn    (fix_syn)
  );

  // next state
  logic [CHK_W-1:0]  chk_d, chk_r;
  logic              cvld_d, cvld_r;
  logic [DATA_W-1:0] q_d, q_r;
  logic              err_d, err_r;
  logic              qvld_d, qvld_r;

  always_comb begin
    chk_d  = chk_r;
    cvld_d = wr_en;
    if (wr_en) chk_d = gen_chk;
    q_d    = q_r;
    err_d  = err_r;
    qvld_d = rd_en;
    if (rd_en) begin
      q_d   = fix_q;
      err_d = fix_err;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      chk_r  <= '0;
      cvld_r <= 1'b0;
      q_r    <= '0;
      err_r  <= 1'b0;
      qvld_r <= 1'b0;
    end else begin
      chk_r  <= chk_d;
      cvld_r <= cvld_d;
      q_r    <= q_d;
      err_r  <= err_d;
      qvld_r <= qvld_d;
    end
  end

  assign wr_chk     = chk_r;
  assign wr_chk_vld = cvld_r;
  assign rd_q       = q_r;
  assign rd_err     = err_r;
  assign rd_q_vld   = qvld_r;

  // assertions
  AST_ZERO_WORD_CHK: assert property (@(posedge clk) disable iff (!rst_q_n)
    (wr_en && wr_data == '0) |=> (wr_chk_vld && wr_chk == '0)); // R1
  AST_RD_VLD_RISE: assert property (@(posedge clk) disable iff (!rst_q_n)
    rd_en |=> rd_q_vld); // R2
  AST_RD_VLD_IDLE: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rd_en |=> !rd_q_vld); // R2
  AST_CLEAN_PASS: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && !ecc_off && fix_syn == '0) |=> (!rd_err && rd_q == $past(rd_data))); // R3
  AST_CHK_ERR_ONLY: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && !ecc_off && $countones(fix_syn) == 1) |=> (rd_err && rd_q == $past(rd_data))); // R5
  AST_BEYOND_RANGE: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && !ecc_off && int'(fix_syn) > CW_LEN) |=> (rd_err && rd_q == $past(rd_data))); // R6
  AST_OFF_RAW: assert property (@(posedge clk) disable iff (!rst_q_n)
    (rd_en && ecc_off) |=> (!rd_err && rd_q == $past(rd_data))); // R7
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !rd_en |=> ($stable(rd_q) && $stable(rd_err))); // R9
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wr_en |=> ($stable(wr_chk) && !wr_chk_vld)); // R9

endmodule

// File: tb/sim_sec16_codec.sv
module sim_sec16_codec;

  localparam int DW = 16;
  localparam int CW = 5;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wr_en;
  logic [DW-1:0] wr_data;
  logic [CW-1:0] wr_chk;
  logic          wr_chk_vld;
  logic          rd_en;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] rd_chk;
  logic          ecc_off;
  logic [DW-1:0] rd_q;
  logic          rd_q_vld;
  logic          rd_err;

  always #10 clk = ~clk;

  sec16_codec #(.DATA_W(DW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .wr_chk(wr_chk), .wr_chk_vld(wr_chk_vld),
    .rd_en(rd_en), .rd_data(rd_data), .rd_chk(rd_chk), .ecc_off(ecc_off),
    .rd_q(rd_q), .rd_q_vld(rd_q_vld), .rd_err(rd_err)
  );

  int    n_chk = 0;
  int    n_err = 0;
  bit    done  = 1'b0;
  string w_tag = "R8";
  string r_tag = "R8";

  logic [CW-1:0] e_chk  = '0;
  logic          e_cvld = 1'b0;
  logic [DW-1:0] e_q    = '0;
  logic          e_err  = 1'b0;
  logic          e_qvld = 1'b0;

  // position of data bit i in the 1-based codeword, skipping 1,2,4,8,16
  function automatic int pos_of(input int i);
    int cnt;
    int res;
    cnt = 0;
    res = 0;
    for (int p = 1; p <= DW + CW; p++) begin
      if (p != 1 && p != 2 && p != 4 && p != 8 && p != 16) begin
        if (cnt == i) res = p;
        cnt++;
      end
    end
    return res;
  endfunction

  function automatic logic [CW-1:0] ref_chk(input logic [DW-1:0] d);
    logic [CW-1:0] c;
    c = '0;
    for (int k = 0; k < CW; k++)
      for (int i = 0; i < DW; i++)
        if (((pos_of(i) >> k) & 1) == 1) c[k] = c[k] ^ d[i];
    return c;
  endfunction

  task automatic compare();
    n_chk++;
    if (wr_chk_vld !== e_cvld || wr_chk !== e_chk) begin
      n_err++;
      $display("FAIL %s: wr_chk=%h vld=%b, expected wr_chk=%h vld=%b",
               w_tag, wr_chk, wr_chk_vld, e_chk, e_cvld);
    end
    n_chk++;
    if (rd_q_vld !== e_qvld || rd_q !== e_q || rd_err !== e_err) begin
      n_err++;
      $display("FAIL %s: rd_q=%h err=%b vld=%b, expected rd_q=%h err=%b vld=%b",
               r_tag, rd_q, rd_err, rd_q_vld, e_q, e_err, e_qvld);
    end
  endtask

  task automatic cycle(input bit we, input logic [DW-1:0] wd, input string wt,
                       input bit re, input logic [DW-1:0] rd, input logic [CW-1:0] rc,
                       input bit off, input string rt);
    int syn;
    @(negedge clk);
    compare();
    wr_en = we; wr_data = wd; rd_en = re; rd_data = rd; rd_chk = rc; ecc_off = off;
    w_tag = wt; r_tag = rt;
    e_cvld = we;
    if (we) e_chk = ref_chk(wd);
    e_qvld = re;
    if (re) begin
      syn = int'(rc ^ ref_chk(rd));
      e_q = rd;
      if (off || syn == 0) e_err = 1'b0;
      else begin
        e_err = 1'b1;
        for (int i = 0; i < DW; i++) if (pos_of(i) == syn) e_q[i] = ~e_q[i];
      end
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL R2: watchdog, actual=still running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] d;
    logic [DW-1:0] pats [6];
    pats = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h0001, 16'h8000, 16'h1234};
    rst_n = 1'b0; wr_en = 0; wr_data = '0; rd_en = 0; rd_data = '0; rd_chk = '0; ecc_off = 0;
    repeat (3) @(negedge clk);
    compare(); // R8 during reset
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 encode patterns
    foreach (pats[j]) cycle(1, pats[j], "R1", 0, 16'h0, 5'h0, 0, "R8");
    // R3 clean reads
    foreach (pats[j]) cycle(0, 16'h0, "R9", 1, pats[j], ref_chk(pats[j]), 0, "R3");
    // R4 every single data bit flipped
    for (int i = 0; i < DW; i++) begin
      d = 16'($urandom);
      cycle(0, 16'h0, "R9", 1, d ^ (16'h1 << i), ref_chk(d), 0, "R4");
    end
    // R5 every single check bit flipped
    for (int k = 0; k < CW; k++) begin
      d = 16'($urandom);
      cycle(0, 16'h0, "R9", 1, d, ref_chk(d) ^ (5'h1 << k), 0, "R5");
    end
    // R6 syndromes 22..31
    for (int s = 22; s < 32; s++) begin
      d = 16'($urandom);
      cycle(0, 16'h0, "R9", 1, d, ref_chk(d) ^ 5'(s), 0, "R6");
    end
    // R7 correction disabled, with and without corruption
    for (int i = 0; i < 8; i++) begin
      d = 16'($urandom);
      cycle(0, 16'h0, "R9", 1, d ^ (16'h1 << (2 * i)), ref_chk(d) ^ 5'(i), 1, "R7");
    end
    // R9 hold: flagged read, then idle cycles with moving inputs
    d = 16'hC3C3;
    cycle(1, 16'h7777, "R1", 1, d ^ 16'h0010, ref_chk(d), 0, "R4");
    for (int i = 0; i < 4; i++)
      cycle(0, 16'($urandom), "R9", 0, 16'($urandom), 5'($urandom), i[0], "R9");
    // R2 mixed random traffic
    for (int i = 0; i < 300; i++) begin
      d = 16'($urandom);
      cycle(1'($urandom), 16'($urandom), "R2",
            1'($urandom), d ^ ((i % 3 == 0) ? (16'h1 << (i % DW)) : 16'h0),
            ref_chk(d), ((i % 7) == 0), "R2");
    end
    cycle(0, 16'h0, "R9", 0, 16'h0, 5'h0, 0, "R2");
    @(negedge clk);
    compare();
    done = 1'b1;
    summary();
    $finish;
  end

endmodule